// File: doc/BRIEF.md
# Serial Boot Image Loader

This block takes a boot image arriving one byte at a time from a serial receiver, checks it, and copies its body into on-chip memory through a word write port. An image starts with two 32-bit header fields: first the destination address, then the body length in 32-bit words. Both are sent most significant byte first. The body words follow, and a 32-bit checksum closes the image. The length counts body words only. It leaves out the eight header bytes and the four checksum bytes.

The header is checked before any write takes place. The body must hold at least one word and no more than `MAX_WORDS` words (128 KB by default). The whole destination range must lie inside a fixed window, 0x0202_0000 to 0x0203_FFFF by default. If the header fails, the loader reports a 3-bit code and goes straight back to waiting for a new header. After a good header, every body word is written to consecutive word addresses. The closing checksum is then compared with the 32-bit wrapping sum of those words. A match gives a one-cycle launch pulse and the jump target. A mismatch gives an error code. Either way, the loader then waits for the next image without being told to.

Both data paths use valid/ready. A byte moves when `in_valid` and `in_ready` are both high at a clock edge. The loader drops `in_ready` while a full word is waiting to be consumed. In the body, that means while the write port is stalled, so back-pressure from memory reaches the serial side with no extra buffering. Once `mem_valid` rises, it stays high with a stable address and data until `mem_ready` takes the word.

Top module: `boot_image_loader`

## Requirements
- R1: A byte is taken only on a clock edge where `in_valid` and `in_ready` are both high. Header bytes are packed most significant byte first: the first four bytes form the destination and the next four form the word count.
- R2: Body word n is presented on the write port with address destination + 4n and its four bytes packed most significant first. While `mem_valid` is high and `mem_ready` is low, address and data hold and `in_ready` stays low.
- R3: A word count of 0 or above `MAX_WORDS` (32768) sets `err_code` to 3'b010, and nothing is written.
- R4: A destination below 0x0202_0000 or above 0x0203_FFFF sets `err_code` to 3'b011, and nothing is written.
- R5: If destination + 4·count − 1 is beyond 0x0203_FFFF, `err_code` is set to 3'b011 and nothing is written. An image ending exactly at 0x0203_FFFF is accepted.
- R6: When the count is illegal, 3'b010 is reported whatever the destination is.
- R7: If the closing word equals the 32-bit wrapping sum of the body words, `boot_go` pulses for exactly one cycle, `boot_pc` shows the destination, and `err_code` is 3'b000.
- R8: If the closing word differs from that sum, `err_code` becomes 3'b100 and `boot_go` stays low.
- R9: After any outcome (launch or error), the next byte offered is taken as the first byte of a new header.
- R10: `err_code` keeps its value until the first byte of the next image is taken. From the following cycle it reads 3'b000.
- R11: A `restart` pulse drops any partly received image. The next byte is then treated as the start of a header, and `err_code` and `boot_pc` are left unchanged.
- R12: After reset, `in_ready` is 1 and `mem_valid`, `boot_go` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous request to abandon the current image |
| in_valid | input | 1 | Byte on `in_byte` is valid |
| in_ready | output | 1 | Loader can take a byte |
| in_byte | input | 8 | Serial byte stream |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Byte address of the word being written |
| mem_data | output | 32 | Word being written |
| boot_go | output | 1 | One-cycle launch pulse |
| boot_pc | output | 32 | Jump target, valid from the `boot_go` pulse on |
| err_code | output | 3 | 000 ok, 010 size, 011 address, 100 checksum |

## Verification
The case that matters most is a write port stall landing in the same cycle a new byte is offered. The byte must wait, and the stalled word must neither be repeated nor lost. The bench provokes this by randomizing `mem_ready` each cycle and inserting random gaps in the byte stream. A directed case also holds the write port low across a word boundary. The outcome is judged by the exact list of addresses and data that crossed the write port, and by the launch or checksum result that depends on every one of those words.

// File: rtl/bldr_pkg.sv
package bldr_pkg;

  typedef enum logic [2:0] {
    BL_OK    = 3'b000,
    BL_ESIZE = 3'b010,
    BL_EADDR = 3'b011,
    BL_ESUM  = 3'b100
  } bl_err_e;

  typedef enum logic [2:0] {
    ST_DEST,
    ST_LEN,
    ST_CHECK,
    ST_BODY,
    ST_SUM
  } bl_state_e;

endpackage

// File: rtl/bldr_word_pack.sv
module bldr_word_pack #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  localparam int WORD_W = BYTE_W * BYTES,
  localparam int CNT_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              take,
  output logic [WORD_W-1:0] word_out,
  output logic              full,
  output logic              at_start
);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q;
  logic              full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      full_q <= 1'b0;
    end else if (flush) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (take) full_q <= 1'b0;
      if (push) begin
        sr_q <= {sr_q[WORD_W-BYTE_W-1:0], byte_in};
        if (cnt_q == CNT_W'(BYTES - 1)) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_out = sr_q;
  assign full     = full_q;
  assign at_start = (cnt_q == '0) && !full_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !push) else $error("byte pushed into a full word"); // R1

  AST_FULL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> cnt_q == '0) else $error("partial count while word full"); // R1

endmodule

// File: rtl/bldr_hdr_check.sv
module bldr_hdr_check
  import bldr_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_LO    = 32'h0202_0000,
  parameter logic [ADDR_W-1:0] WIN_HI    = 32'h0203_FFFF,
  parameter int                MAX_WORDS = 32768,
  localparam int EXT_W = ADDR_W + 2
) (
  input  logic [ADDR_W-1:0] dst,
  input  logic [ADDR_W-1:0] len,
  output bl_err_e           verdict
);

  logic [EXT_W-1:0] span_end;
  logic             size_bad;
  logic             base_bad;
  logic             end_bad;

  always_comb begin
    span_end = {2'b00, dst} + {len, 2'b00} - EXT_W'(1);
    size_bad = (len == '0) || (len > ADDR_W'(MAX_WORDS));
    base_bad = (dst < WIN_LO) || (dst > WIN_HI);
    end_bad  = span_end > {2'b00, WIN_HI};
    if (size_bad)                 verdict = BL_ESIZE;
    else if (base_bad || end_bad) verdict = BL_EADDR;
    else                          verdict = BL_OK;
  end

endmodule

// File: rtl/bldr_csum.sv
module bldr_csum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] word,
  output logic [W-1:0] sum
);

  logic [W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (add) acc_q <= acc_q + word;
  end

  assign sum = acc_q;

endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
  import bldr_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] WIN_LO    = 32'h0202_0000,
  parameter logic [31:0] WIN_HI    = 32'h0203_FFFF,
  parameter int          MAX_WORDS = 32768,
  localparam int BYTE_W = 8,
  localparam int BYTES  = ADDR_W / BYTE_W,
  localparam int LEN_W  = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_data,
  output logic              boot_go,
  output logic [ADDR_W-1:0] boot_pc,
  output logic [2:0]        err_code
);

  bl_state_e         state_q;
  bl_err_e           err_q;
  bl_err_e           verdict;
  logic [ADDR_W-1:0] dst_q, len_q, cur_q, pc_q;
  logic [LEN_W-1:0]  left_q;
  logic              go_q;

  logic              push, take, beat;
  logic              full, at_start;
  logic [ADDR_W-1:0] word;
  logic [ADDR_W-1:0] sum;

  assign in_ready  = !full && (state_q != ST_CHECK);
  assign push      = in_valid && in_ready;
  assign mem_valid = full && (state_q == ST_BODY);
  assign beat      = mem_valid && mem_ready;
  assign take      = beat || (full && (state_q == ST_DEST || state_q == ST_LEN ||
                                       state_q == ST_SUM));

  bldr_word_pack #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (restart),
    .push     (push),
    .byte_in  (in_byte),
    .take     (take),
    .word_out (word),
    .full     (full),
    .at_start (at_start)
  );

  bldr_hdr_check #(
    .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .MAX_WORDS(MAX_WORDS)
  ) u_hdr (
    .dst     (dst_q),
    .len     (len_q),
    .verdict (verdict)
  );

  bldr_csum #(.W(ADDR_W)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == ST_CHECK),
    .add   (beat),
    .word  (word),
    .sum   (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DEST;
      err_q   <= BL_OK;
      dst_q   <= '0;
      len_q   <= '0;
      cur_q   <= '0;
      left_q  <= '0;
      pc_q    <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (restart) begin
        state_q <= ST_DEST;
      end else begin
        if (push && state_q == ST_DEST && at_start) err_q <= BL_OK;
        case (state_q)
          ST_DEST: if (full) begin
            dst_q   <= word;
            state_q <= ST_LEN;
          end
          ST_LEN: if (full) begin
            len_q   <= word;
            state_q <= ST_CHECK;
          end
          ST_CHECK: begin
            if (verdict != BL_OK) begin
              err_q   <= verdict;
              state_q <= ST_DEST;
            end else begin
              cur_q   <= dst_q;
              left_q  <= len_q[LEN_W-1:0];
              state_q <= ST_BODY;
            end
          end
          ST_BODY: if (beat) begin
            cur_q  <= cur_q + ADDR_W'(BYTES);
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) state_q <= ST_SUM;
          end
          ST_SUM: if (full) begin
            if (word == sum) begin
              go_q <= 1'b1;
              pc_q <= dst_q;
            end else begin
              err_q <= BL_ESUM;
            end
            state_q <= ST_DEST;
          end
          default: state_q <= ST_DEST;
        endcase
      end
    end
  end

  assign mem_addr = cur_q;
  assign mem_data = word;
  assign boot_go  = go_q;
  assign boot_pc  = pc_q;
  assign err_code = err_q;

  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr >= WIN_LO) && (mem_addr <= WIN_HI))
    else $error("write outside window"); // R5

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !restart) |=>
      mem_valid && $stable(mem_addr) && $stable(mem_data))
    else $error("stalled write changed"); // R2

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !in_ready) else $error("byte taken during stalled write"); // R2

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_go |=> !boot_go) else $error("launch longer than one cycle"); // R7

  AST_GO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    boot_go |-> err_code == 3'b000) else $error("launch with error code"); // R7

  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    err_code inside {3'b000, 3'b010, 3'b011, 3'b100})
    else $error("illegal error code"); // R3

endmodule

// File: tb/boot_image_loader_tb.sv
module boot_image_loader_tb;

  localparam logic [31:0] LO = 32'h0202_0000;
  localparam logic [31:0] HI = 32'h0203_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_data;
  logic        boot_go;
  logic [31:0] boot_pc;
  logic [2:0]  err_code;

  always #2 clk = ~clk;

  boot_image_loader u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .boot_go(boot_go), .boot_pc(boot_pc), .err_code(err_code)
  );

  int          n_chk = 0, n_bad = 0;
  int          wcnt = 0, gocnt = 0;
  logic [31:0] wa [0:63];
  logic [31:0] wd [0:63];
  logic [31:0] pay [0:63];
  logic [31:0] gopc = '0;
  logic [2:0]  prev_err = 3'b000;
  bit          bp_on = 0, stall = 0, rand_gap = 0, finished = 0;

  // write port and launch monitor, runs between edges
  always @(negedge clk) begin
    bit r;
    r = stall ? 1'b0 : (bp_on ? ($urandom_range(0, 3) != 0) : 1'b1);
    mem_ready = r;
    if (rst_n) begin
      if (mem_valid && r) begin
        if (wcnt < 64) begin
          wa[wcnt] = mem_addr;
          wd[wcnt] = mem_data;
        end
        wcnt++;
      end
      if (boot_go) begin
        gocnt++;
        gopc = boot_pc;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] hdr_code(logic [31:0] d, logic [31:0] l);
    logic [33:0] e;
    e = {2'b00, d} + {l, 2'b00} - 34'd1;
    if (l == 0 || l > 32'd32768) return 3'b010;
    if (d < LO || d > HI)        return 3'b011;
    if (e > {2'b00, HI})         return 3'b011;
    return 3'b000;
  endfunction

  function automatic logic [31:0] body_sum(int n);
    logic [31:0] s = '0;
    for (int i = 0; i < n; i++) s = s + pay[i];
    return s;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    if (rand_gap) repeat ($urandom_range(0, 2)) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
  endtask

  task automatic run_image(input logic [31:0] d, input logic [31:0] l,
                           input bit corrupt, input string tag);
    logic [2:0]  h, exp;
    logic [31:0] s;
    int          bad_a, bad_d;
    string       et;
    wcnt = 0; gocnt = 0;
    h   = hdr_code(d, l);
    exp = (h != 0) ? h : (corrupt ? 3'b100 : 3'b000);
    chk({"R10 code held before next image ", tag}, 32'(err_code), 32'(prev_err));
    send_byte(d[31:24]);
    chk({"R10 code cleared on first byte ", tag}, 32'(err_code), 32'd0);
    send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
    send_word(l);
    if (h == 0) begin
      for (int i = 0; i < int'(l); i++) send_word(pay[i]);
      s = body_sum(int'(l));
      send_word(corrupt ? (s ^ 32'h0000_0100) : s);
    end
    repeat (8) @(negedge clk);
    et = (h == 3'b010) ? "R3" : (h == 3'b011) ? "R4" : corrupt ? "R8" : "R7";
    chk({et, " error code ", tag}, 32'(err_code), 32'(exp));
    chk({et, " launch count ", tag}, gocnt, (exp == 0) ? 1 : 0);
    if (exp == 0) chk({"R7 jump target ", tag}, gopc, d);
    if (h == 0) begin
      chk({"R2 write count ", tag}, wcnt, l);
      bad_a = 0; bad_d = 0;
      for (int i = 0; i < wcnt && i < 64; i++) begin
        if (wa[i] !== d + 32'(4 * i)) bad_a++;
        if (wd[i] !== pay[i]) bad_d++;
      end
      chk({"R1 write addresses ", tag}, bad_a, 0);
      chk({"R2 write data ", tag}, bad_d, 0);
    end else begin
      chk({et, " no write on bad header ", tag}, wcnt, 0);
    end
    prev_err = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, l;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R12 reset in_ready", 32'(in_ready), 1);
    chk("R12 reset mem_valid", 32'(mem_valid), 0);
    chk("R12 reset boot_go", 32'(boot_go), 0);
    chk("R12 reset err_code", 32'(err_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    pay[0] = 32'h1122_3344; pay[1] = 32'hA5A5_0F0F; pay[2] = 32'h0000_0001;
    run_image(LO, 3, 0, "basic");
    run_image(LO, 0, 0, "zero length");
    run_image(LO, 32769, 0, "one over limit");
    run_image(32'h0, 0, 0, "R6 size before address");
    run_image(32'h0500_0000, 32'hFFFF_FFFF, 0, "R6 huge length bad base");
    pay[0] = 32'hDEAD_BEEF;
    run_image(32'h0203_FFFC, 1, 0, "R9 recovers, last word of window");
    run_image(32'h0201_FFFC, 1, 0, "base below window");
    run_image(32'h0204_0000, 1, 0, "base above window");
    run_image(32'h0203_FFFC, 2, 0, "R5 end past window");
    run_image(LO + 4, 32768, 0, "R5 R6 max length shifted");
    pay[0] = 32'h0102_0304; pay[1] = 32'h0506_0708;
    run_image(LO + 32'h100, 2, 1, "bad checksum");
    pay[0] = 32'hFFFF_FFFF; pay[1] = 32'hFFFF_FFFF; pay[2] = 32'hFFFF_FFFF;
    run_image(LO + 32'h40, 3, 0, "R7 wrapping sum");

    // directed back-pressure across a word boundary
    wcnt = 0; gocnt = 0;
    pay[0] = 32'hCAFE_0001; pay[1] = 32'hCAFE_0002;
    stall = 1;
    send_word(LO + 32'h200); send_word(2); send_word(pay[0]);
    repeat (5) @(negedge clk);
    chk("R2 stalled word offered", 32'(mem_valid), 1);
    chk("R2 input blocked while stalled", 32'(in_ready), 0);
    chk("R2 stalled address", mem_addr, LO + 32'h200);
    chk("R2 stalled data", mem_data, pay[0]);
    stall = 0;
    send_word(pay[1]); send_word(body_sum(2));
    repeat (8) @(negedge clk);
    chk("R2 writes after stall", wcnt, 2);
    chk("R7 launch after stall", gocnt, 1);
    prev_err = 3'b000;

    // restart in the middle of a body
    wcnt = 0; gocnt = 0;
    send_word(LO + 32'h300); send_word(4); send_word(32'h1); send_word(32'h2);
    repeat (6) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R11 partial writes kept", wcnt, 2);
    chk("R11 no launch from partial", gocnt, 0);
    chk("R11 ready after restart", 32'(in_ready), 1);
    chk("R11 code unchanged", 32'(err_code), 32'(prev_err));
    chk("R11 target unchanged", boot_pc, LO + 32'h200);
    pay[0] = 32'h7777_0000; pay[1] = 32'h0000_7777;
    run_image(LO + 32'h400, 2, 0, "R11 after restart");

    // random images
    bp_on = 1; rand_gap = 1;
    for (int k = 0; k < 24; k++) begin
      l = 32'($urandom_range(1, 10));
      if ($urandom_range(0, 5) == 0) d = 32'h0204_0000 + 32'($urandom_range(0, 255) * 4);
      else d = LO + 32'($urandom_range(0, 32768 - int'(l)) * 4);
      for (int i = 0; i < int'(l); i++) pay[i] = $urandom;
      run_image(d, l, ($urandom_range(0, 3) == 0), $sformatf("random %0d", k));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule